// File: doc/BRIEF.md
# Asynchronous Write Wait-State Sequencer

This block runs a single asynchronous write cycle to an external device. A start pulse latches the write data and launches a cycle-time counter. Two programmable windows on that counter produce a chip-select strobe and a write strobe. The data bus is driven for the whole cycle. A one-clock done pulse marks the end of the cycle, and the block then accepts the next start.

The device can stretch the cycle through its wait pin. The pin passes through a fixed two-flop synchronizer. Once the counter reaches the programmed access time, an active synchronized wait freezes the counter, and every output then holds its level. When wait goes inactive, an optional extra delay keeps the freeze for a few more cycles. That delay is counted in divided clock ticks. Monitoring can be switched off, and the active level of the pin is selectable.

The timing and control configuration inputs must stay stable while a cycle runs. Only the write data is latched at start.

Top module: `awr_wait_seq`

## Requirements
- R1: After reset, and whenever no cycle runs, cs_o, we_o, data_oe_o and done_o are 0 and data_o is 0.
- R2: start_i is accepted only when no cycle runs. A start during a cycle has no effect on its length or on data_o, and produces no extra done pulse.
- R3: During a cycle, data_oe_o is 1 and data_o equals data_i as sampled at start. cs_o is 1 exactly while the counter value c satisfies cs_on_i <= c < cs_off_i. we_o follows the same rule with we_on_i and we_off_i.
- R4: With no freeze, the counter reads 0 in the first clock after start is sampled. done_o is a single-clock pulse, high exactly cycle_time_i clocks after that first clock.
- R5: When wait_mon_en_i is 0, the wait pin has no effect on cycle length or outputs.
- R6: Wait is acted on only once the counter has reached wr_access_i. Wait seen before that point does not lengthen the cycle.
- R7: The pin reaches the freeze logic through a two-clock synchronizer. Let the pin go inactive in clock R, counted from the counter's first clock. The counter is then frozen for max(0, R+2-wr_access_i) clocks.
- R8: While frozen, the counter stays where it is and cs_o, we_o, data_o and data_oe_o hold their values.
- R9: A freeze caused by wait is extended by extra_dly_i*(clk_div_i+1) clocks after synchronized wait goes inactive. extra_dly_i is a 2-bit tick count and clk_div_i a 2-bit divider (divide by 1 to 4). No extension is added when wait never froze the counter.
- R10: wait_pol_i selects the active pin level: 1 means the pin is active high, 0 means active low. Active means the device is not ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse for one write cycle |
| wr_access_i | input | CNT_W | Counter value at which wait monitoring begins |
| cycle_time_i | input | CNT_W | Total cycle length in counter steps (at least 1) |
| cs_on_i | input | CNT_W | Chip-select assert count |
| cs_off_i | input | CNT_W | Chip-select deassert count |
| we_on_i | input | CNT_W | Write-strobe assert count |
| we_off_i | input | CNT_W | Write-strobe deassert count |
| wait_mon_en_i | input | 1 | Enable wait monitoring |
| wait_pol_i | input | 1 | Active level of the wait pin |
| extra_dly_i | input | 2 | Extra unfreeze delay in divided ticks |
| clk_div_i | input | 2 | Tick divider minus one |
| data_i | input | DATA_W | Write data, latched at start |
| wait_i | input | 1 | Device wait pin, asynchronous |
| cs_o | output | 1 | Chip-select strobe |
| we_o | output | 1 | Write strobe |
| data_oe_o | output | 1 | Data bus drive enable |
| data_o | output | DATA_W | Write data bus |
| done_o | output | 1 | One-clock end-of-cycle pulse |

## Verification
The bench moves the wait release around the access-time point, one clock before and exactly at the boundary. A design with the wrong synchronizer depth or the wrong window comparison stretches these cycles by one clock too many or too few. It runs several combinations of delay ticks and divider values, and also a case where wait clears before access time. A design that multiplies wrongly, or adds the delay without a real freeze, ends the cycle at the wrong clock. Monitoring is disabled with the pin held active, the pin polarity is inverted, and a second start arrives mid-cycle. A design that ignores these controls either stalls, never stretches, or restarts with new data. Strobes and data are compared every clock against a frozen-aware model of the counter, so any output that moves during a freeze is caught.

// File: rtl/awr_pkg.sv
package awr_pkg;
  localparam int unsigned DLY_W = 4;  // holds 3 ticks * 4 divided clocks

  function automatic logic [DLY_W-1:0] dly_clocks(input logic [1:0] ticks, input logic [1:0] div);
    return DLY_W'(ticks) * (DLY_W'(div) + DLY_W'(1));
  endfunction
endpackage

// File: rtl/awr_wait_sync.sv
module awr_wait_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], d_i};
  end

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/awr_unfreeze_dly.sv
module awr_unfreeze_dly
  import awr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       launch_i,
  input  logic [1:0] ticks_i,
  input  logic [1:0] div_i,
  output logic       hold_o
);
  logic [DLY_W-1:0] rem_q;
  logic [DLY_W-1:0] len;

  assign len    = dly_clocks(ticks_i, div_i);
  // launch clock is the first held clock
  assign hold_o = (launch_i && len != '0) || rem_q != '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       rem_q <= '0;
    else if (launch_i && len != '0)    rem_q <= len - DLY_W'(1);
    else if (rem_q != '0)              rem_q <= rem_q - DLY_W'(1);
  end
endmodule

// File: rtl/awr_strobe_win.sv
module awr_strobe_win #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] on_i,
  input  logic [CNT_W-1:0] off_i,
  output logic             out_o
);
  assign out_o = en_i && (cnt_i >= on_i) && (cnt_i < off_i);
endmodule

// File: rtl/awr_wait_seq.sv
module awr_wait_seq #(
  parameter int unsigned CNT_W       = 6,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  wr_access_i,
  input  logic [CNT_W-1:0]  cycle_time_i,
  input  logic [CNT_W-1:0]  cs_on_i,
  input  logic [CNT_W-1:0]  cs_off_i,
  input  logic [CNT_W-1:0]  we_on_i,
  input  logic [CNT_W-1:0]  we_off_i,
  input  logic              wait_mon_en_i,
  input  logic              wait_pol_i,
  input  logic [1:0]        extra_dly_i,
  input  logic [1:0]        clk_div_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              wait_i,
  output logic              cs_o,
  output logic              we_o,
  output logic              data_oe_o,
  output logic [DATA_W-1:0] data_o,
  output logic              done_o
);
  localparam int unsigned NUM_WIN = 2;

  logic              busy_q, done_q, frz_prev_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] data_q;
  logic              wait_s, act_s, frz_wait, launch, hold, frz, last;

  awr_wait_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(wait_i), .q_o(wait_s)
  );

  assign act_s    = wait_s ~^ wait_pol_i;
  assign frz_wait = wait_mon_en_i && busy_q && (cnt_q >= wr_access_i) && act_s;
  assign launch   = frz_prev_q && !frz_wait;

  awr_unfreeze_dly i_dly (
    .clk_i(clk_i), .rst_ni(rst_ni), .launch_i(launch),
    .ticks_i(extra_dly_i), .div_i(clk_div_i), .hold_o(hold)
  );

  assign frz  = frz_wait || hold;
  assign last = busy_q && !frz && (cnt_q == cycle_time_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      frz_prev_q <= 1'b0;
      cnt_q      <= '0;
      data_q     <= '0;
    end else begin
      done_q     <= 1'b0;
      frz_prev_q <= frz_wait;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
          data_q <= data_i;
        end
      end else if (!frz) begin
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          cnt_q  <= '0;
        end else begin
          cnt_q  <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  logic [NUM_WIN-1:0][CNT_W-1:0] win_on, win_off;
  logic [NUM_WIN-1:0]            win_out;
  assign win_on  = {we_on_i, cs_on_i};
  assign win_off = {we_off_i, cs_off_i};

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    awr_strobe_win #(.CNT_W(CNT_W)) i_win (
      .en_i(busy_q), .cnt_i(cnt_q), .on_i(win_on[g]), .off_i(win_off[g]), .out_o(win_out[g])
    );
  end

  assign cs_o      = win_out[0];
  assign we_o      = win_out[1];
  assign data_oe_o = busy_q;
  assign data_o    = busy_q ? data_q : '0;
  assign done_o    = done_q;
endmodule

// File: rtl/awr_wait_seq_chk.sv
module awr_wait_seq_chk #(
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_q,
  input logic              frz,
  input logic              hold,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              wait_mon_en_i,
  input logic              cs_o,
  input logic              we_o,
  input logic              data_oe_o,
  input logic [DATA_W-1:0] data_o,
  input logic              done_o
);
  p_quiet_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> (!cs_o && !we_o && !data_oe_o && data_o == '0));

  p_done_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_after_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_q));

  p_mon_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !wait_mon_en_i && !hold) |-> !frz);

  p_stall_cnt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && frz) |=> (cnt_q == $past(cnt_q)));

  p_hold_out_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && frz) |=> ($stable(cs_o) && $stable(we_o) && $stable(data_o) && data_oe_o));
endmodule

bind awr_wait_seq awr_wait_seq_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_awr_wait_seq.sv
`timescale 1ns/1ps
module test_awr_wait_seq;
  localparam int CNT_W  = 6;
  localparam int DATA_W = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [CNT_W-1:0] wr_access_i = '0, cycle_time_i = '0;
  logic [CNT_W-1:0] cs_on_i = '0, cs_off_i = '0, we_on_i = '0, we_off_i = '0;
  logic wait_mon_en_i = 1'b0, wait_pol_i = 1'b1;
  logic [1:0] extra_dly_i = '0, clk_div_i = '0;
  logic [DATA_W-1:0] data_i = '0;
  logic wait_i = 1'b0;
  logic cs_o, we_o, data_oe_o, done_o;
  logic [DATA_W-1:0] data_o;

  int vectors = 0;
  int errors  = 0;
  int cyc     = 0;
  int exp_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  awr_wait_seq #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_awr_wait_seq (.clk_i(clk), .*);

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // monitor: pops expected done cycle when done_o is seen
  always @(negedge clk) begin
    if (rst_ni && done_o) begin
      if (exp_q.size() == 0) check("R2 unexpected done", 1, 0);
      else check("R4 done cycle", cyc, exp_q.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check("watchdog", 1, 0);
    report();
  end

  task automatic run(input int t, input int a, input int cs_on, input int cs_off,
                     input int we_on, input int we_off, input bit mon, input bit pol,
                     input int ext, input int div, input bit wt, input int r,
                     input int data, input bit mid_start, input string req);
    int w, d, total, s;
    @(negedge clk);
    cycle_time_i = CNT_W'(t); wr_access_i = CNT_W'(a);
    cs_on_i = CNT_W'(cs_on); cs_off_i = CNT_W'(cs_off);
    we_on_i = CNT_W'(we_on); we_off_i = CNT_W'(we_off);
    wait_mon_en_i = mon; wait_pol_i = pol;
    extra_dly_i = 2'(ext); clk_div_i = 2'(div);
    data_i = DATA_W'(data);
    wait_i = wt ? pol : ~pol;
    repeat (3) @(negedge clk);
    w = (wt && mon && (r + 2 > a)) ? r + 2 - a : 0;
    d = (w > 0) ? ext * (div + 1) : 0;
    total = t + w + d;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    s = cyc;
    exp_q.push_back(s + total);
    for (int c = 0; c <= total; c++) begin
      int eff;
      eff = (c <= a) ? c : ((c <= a + w + d) ? a : c - w - d);
      if (c < total) begin
        check({req, " R3 cs"}, int'(cs_o), int'(eff >= cs_on && eff < cs_off));
        check({req, " R8 we"}, int'(we_o), int'(eff >= we_on && eff < we_off));
        check({req, " R3 oe"}, int'(data_oe_o), 1);
        check({req, " R2 data"}, int'(data_o), data);
      end else begin
        check({req, " R1 oe at end"}, int'(data_oe_o), 0);
      end
      if (c == r) wait_i = ~pol;
      if (mid_start && c == 5) begin start_i = 1'b1; data_i = ~DATA_W'(data); end
      else start_i = 1'b0;
      @(negedge clk);
    end
    start_i = 1'b0;
    wait_i = ~pol;
    repeat (2) @(negedge clk);
    check({req, " R4 queue drained"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 cs reset", int'(cs_o), 0);
    check("R1 we reset", int'(we_o), 0);
    check("R1 oe reset", int'(data_oe_o), 0);
    check("R1 done reset", int'(done_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 data idle", int'(data_o), 0);
    //   t  a  cs    we   mon pol ext div wt  r   data
    run(12, 4, 1,10, 3,9, 1, 1, 0, 0, 0, 99, 16'hA5A5, 0, "R4 plain");
    run(12, 4, 1,10, 3,9, 1, 1, 0, 0, 1, 8,  16'h1234, 0, "R7 wait");
    run(12, 4, 1,10, 3,9, 1, 1, 2, 1, 1, 8,  16'h00FF, 0, "R9 delay2x2");
    run(12, 4, 1,10, 3,9, 1, 1, 3, 3, 1, 5,  16'hBEEF, 0, "R9 delay3x4");
    run(12, 4, 1,10, 3,9, 0, 1, 2, 1, 1, 99, 16'h5555, 0, "R5 mon off");
    run(12, 4, 1,10, 3,9, 1, 1, 2, 0, 1, 1,  16'h0F0F, 0, "R6 early release");
    run(12, 4, 1,10, 3,9, 1, 1, 0, 0, 1, 2,  16'h0001, 0, "R6 boundary");
    run(12, 4, 1,10, 3,9, 1, 1, 1, 0, 1, 3,  16'h0002, 0, "R7 one clock");
    run(12, 4, 1,10, 3,9, 1, 0, 0, 0, 1, 6,  16'hC3C3, 0, "R10 active low");
    run(10, 0, 0,6,  2,8, 1, 1, 0, 0, 1, 0,  16'h7777, 0, "R7 access zero");
    run(12, 4, 1,10, 3,9, 1, 1, 0, 0, 0, 99, 16'h2468, 1, "R2 start busy");
    report();
  end
endmodule